// File: doc/BRIEF.md
# Transposed-RAM Exact-Match Table

This block is a small exact-match lookup table built entirely from ordinary addressable storage. It does not compare an incoming key against every stored key. A row store indexed by the key holds a bit vector with one bit per table entry, and a set bit marks that the entry holds this key. A second store indexed by the entry number holds the value bound to each entry. Free entries are tracked in a bitmap, and the lowest free entry is allocated on insert.

Operations are issued one per cycle on a single command port: insert a key with a value, delete a key, or look a key up. The row vector for the key is read in the cycle after the command. In the following cycle it is decoded, then updated and written back. A result pulse reports success, the entry number and, for a lookup, the stored value. A full flag shows when every entry is taken. Commands may be issued on consecutive cycles, even to the same key: a row written by one command is passed directly to the next command that reads it.

Top module: `xcam_table`

## Requirements
- R1: After reset every entry is free, `tbl_full` is 0, `rsp_valid` is 0, and a lookup of any key misses.
- R2: Command codes on `cmd_op` are 2'b01 insert, 2'b10 delete, 2'b11 lookup and 2'b00 idle. A command sampled at a rising edge produces exactly one `rsp_valid` pulse, visible after the next rising edge. Idle produces no pulse.
- R3: An insert with at least one free entry takes the lowest-numbered free entry, stores the value there, sets `rsp_hit` and reports that entry number on `rsp_index`.
- R4: A lookup of a stored key sets `rsp_hit` and returns the entry number and the value stored for that key.
- R5: A lookup or delete of a key that is not stored clears `rsp_hit` and drives `rsp_index` and `rsp_value` to zero.
- R6: A key may be inserted more than once, and each insert takes its own entry. A lookup returns the lowest-numbered entry that holds the key.
- R7: A delete of a stored key frees the lowest-numbered entry holding it and reports that entry. A later lookup returns the next entry with that key, or a miss. The freed entry is the first one reused by the next insert.
- R8: A delete that misses changes no entry. Stored keys still return the same entry and value afterwards.
- R9: When no entry is free, `tbl_full` is 1. An insert then fails with `rsp_hit` 0 and `rsp_index` 0, and it changes no state.
- R10: Commands to the same key on consecutive cycles see each other's updates. This holds for an insert followed by a lookup, two inserts, and a delete followed by a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | Command: 00 idle, 01 insert, 10 delete, 11 lookup |
| cmd_key | input | KEY_W | Key of the command |
| cmd_value | input | VAL_W | Value to store on insert |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_hit | output | 1 | Insert placed, or key found for a lookup or delete |
| rsp_index | output | IDX_W | Entry allocated or matched, zero on failure |
| rsp_value | output | VAL_W | Value found by a lookup, zero otherwise |
| tbl_full | output | 1 | No free entry remains |

## Verification
The first patterns are single keys, and keys that differ from a stored key in one bit. These separate a true row match from aliasing between neighbouring rows. A key inserted several times, then deleted and looked up again, shows whether the lowest entry wins and whether freed entries are reused. Commands to the same key on consecutive cycles expose a stale row read, because without forwarding the second entry or the deletion would be lost. Filling the table around entries freed earlier checks the order of allocation and the rejection of an insert into a full table.

// File: rtl/xcam_table.sv
module xcam_table #(
  parameter int KEY_W   = 8,
  parameter int ENTRIES = 16,
  parameter int VAL_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ROWS   = 1 << KEY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd_op,
  input  logic [KEY_W-1:0] cmd_key,
  input  logic [VAL_W-1:0] cmd_value,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [IDX_W-1:0] rsp_index,
  output logic [VAL_W-1:0] rsp_value,
  output logic             tbl_full
);

  localparam logic [1:0] OP_IDLE = 2'b00;
  localparam logic [1:0] OP_ADD  = 2'b01;
  localparam logic [1:0] OP_DEL  = 2'b10;
  localparam logic [1:0] OP_FIND = 2'b11;
  localparam logic [ENTRIES-1:0] ONE = {{(ENTRIES-1){1'b0}}, 1'b1};

  logic [ENTRIES-1:0] row_mem [ROWS];
  logic [VAL_W-1:0]   val_mem [ENTRIES];
  logic [ENTRIES-1:0] free_map;

  logic [1:0]         s_op;
  logic [KEY_W-1:0]   s_key;
  logic [VAL_W-1:0]   s_val;
  logic [ENTRIES-1:0] s_row;

  function automatic logic [IDX_W-1:0] lowest(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  logic [IDX_W-1:0]   match_idx, alloc_idx;
  logic               found, has_room;
  logic               wr_en;
  logic [ENTRIES-1:0] wr_row;

  assign match_idx = lowest(s_row);
  assign alloc_idx = lowest(free_map);
  assign found     = (|s_row) && !free_map[match_idx];
  assign has_room  = |free_map;
  assign tbl_full  = ~has_room;

  always_comb begin
    wr_en  = 1'b0;
    wr_row = s_row;
    case (s_op)
      OP_ADD: begin
        wr_en  = has_room;
        wr_row = s_row | (ONE << alloc_idx);
      end
      OP_DEL: begin
        wr_en  = found;
        wr_row = s_row & ~(ONE << match_idx);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) row_mem[r] <= '0;
      for (int e = 0; e < ENTRIES; e++) val_mem[e] <= '0;
      free_map <= '1;
      s_op     <= OP_IDLE;
      s_key    <= '0;
      s_val    <= '0;
      s_row    <= '0;
    end else begin
      s_op  <= cmd_op;
      s_key <= cmd_key;
      s_val <= cmd_value;
      s_row <= (wr_en && s_key == cmd_key) ? wr_row : row_mem[cmd_key];
      if (wr_en) row_mem[s_key] <= wr_row;
      if (s_op == OP_ADD && has_room) begin
        val_mem[alloc_idx]  <= s_val;
        free_map[alloc_idx] <= 1'b0;
      end
      if (s_op == OP_DEL && found) begin
        val_mem[match_idx]  <= '0;
        free_map[match_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_index <= '0;
      rsp_value <= '0;
    end else begin
      rsp_valid <= (s_op != OP_IDLE);
      rsp_hit   <= 1'b0;
      rsp_index <= '0;
      rsp_value <= '0;
      case (s_op)
        OP_ADD: if (has_room) begin
          rsp_hit   <= 1'b1;
          rsp_index <= alloc_idx;
        end
        OP_DEL: if (found) begin
          rsp_hit   <= 1'b1;
          rsp_index <= match_idx;
        end
        OP_FIND: if (found) begin
          rsp_hit   <= 1'b1;
          rsp_index <= match_idx;
          rsp_value <= val_mem[match_idx];
        end
        default: ;
      endcase
    end
  end

  a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_index == '0 && rsp_value == '0));

  a_r9_full_insert_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (s_op == OP_ADD && free_map == '0) |=> (free_map == $past(free_map) && rsp_valid && !rsp_hit));

  a_r3_insert_takes_one: assert property (@(posedge clk) disable iff (!rst_n)
    (s_op == OP_ADD && free_map != '0) |=> ($countones(free_map) == $countones($past(free_map)) - 1));

  a_r7_delete_frees_one: assert property (@(posedge clk) disable iff (!rst_n)
    (s_op == OP_DEL && found) |=> ($countones(free_map) == $countones($past(free_map)) + 1));

  a_r8_delete_miss_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (s_op == OP_DEL && !found) |=> $stable(free_map));

  a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (s_op == OP_IDLE) |=> !rsp_valid);

endmodule

// File: tb/test_xcam_table.sv
`timescale 1ns/1ps
module test_xcam_table;
  localparam int KEY_W = 8, ENTRIES = 16, VAL_W = 16, IDX_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [KEY_W-1:0] cmd_key = '0;
  logic [VAL_W-1:0] cmd_value = '0;
  logic rsp_valid, rsp_hit, tbl_full;
  logic [IDX_W-1:0] rsp_index;
  logic [VAL_W-1:0] rsp_value;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xcam_table #(.KEY_W(KEY_W), .ENTRIES(ENTRIES), .VAL_W(VAL_W)) i_xcam_table (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_key(cmd_key), .cmd_value(cmd_value),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_index(rsp_index),
    .rsp_value(rsp_value), .tbl_full(tbl_full));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_rsp(input string tag, input int hit, input int idx, input int val);
    chk({tag, " valid"}, int'(rsp_valid), 1);
    chk({tag, " hit"}, int'(rsp_hit), hit);
    chk({tag, " index"}, int'(rsp_index), idx);
    chk({tag, " value"}, int'(rsp_value), val);
  endtask

  task automatic issue(input logic [1:0] op, input int key, input int val);
    cmd_op = op; cmd_key = KEY_W'(key); cmd_value = VAL_W'(val);
  endtask

  task automatic single(input string tag, input logic [1:0] op, input int key, input int val,
                        input int hit, input int idx, input int rval);
    @(negedge clk); issue(op, key, val);
    @(negedge clk); issue(2'b00, 0, 0);
    @(negedge clk); chk_rsp(tag, hit, idx, rval);
  endtask

  task automatic pair(input string tag,
                      input logic [1:0] op_a, input int key_a, input int val_a,
                      input logic [1:0] op_b, input int key_b, input int val_b,
                      input int hit_a, input int idx_a, input int rv_a,
                      input int hit_b, input int idx_b, input int rv_b);
    @(negedge clk); issue(op_a, key_a, val_a);
    @(negedge clk); issue(op_b, key_b, val_b);
    @(negedge clk); issue(2'b00, 0, 0); chk_rsp({tag, " first"}, hit_a, idx_a, rv_a);
    @(negedge clk); chk_rsp({tag, " second"}, hit_b, idx_b, rv_b);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 full after reset", int'(tbl_full), 0);
    chk("R1 valid after reset", int'(rsp_valid), 0);
    single("R1 R5 lookup empty", 2'b11, 'h12, 0, 0, 0, 0);
  endtask

  task automatic t_basic();
    single("R3 insert first", 2'b01, 'h12, 'hA001, 1, 0, 0);
    single("R4 lookup first", 2'b11, 'h12, 0, 1, 0, 'hA001);
    single("R3 insert second", 2'b01, 'h34, 'hB002, 1, 1, 0);
    single("R4 lookup second", 2'b11, 'h34, 0, 1, 1, 'hB002);
    single("R5 lookup neighbour key", 2'b11, 'h35, 0, 0, 0, 0);
  endtask

  task automatic t_dup();
    single("R6 insert duplicate", 2'b01, 'h12, 'hC003, 1, 2, 0);
    single("R6 lookup lowest", 2'b11, 'h12, 0, 1, 0, 'hA001);
    single("R7 delete lowest", 2'b10, 'h12, 0, 1, 0, 0);
    single("R7 lookup next", 2'b11, 'h12, 0, 1, 2, 'hC003);
    single("R7 reuse freed", 2'b01, 'h56, 'hD004, 1, 0, 0);
    single("R7 lookup reused", 2'b11, 'h56, 0, 1, 0, 'hD004);
  endtask

  task automatic t_del_miss();
    single("R8 R5 delete absent", 2'b10, 'h77, 0, 0, 0, 0);
    single("R8 others intact", 2'b11, 'h34, 0, 1, 1, 'hB002);
  endtask

  task automatic t_b2b();
    pair("R10 insert then lookup", 2'b01, 'h80, 'hE005, 2'b11, 'h80, 0,
         1, 3, 0, 1, 3, 'hE005);
    pair("R10 two inserts", 2'b01, 'h81, 'hF006, 2'b01, 'h81, 'hF007,
         1, 4, 0, 1, 5, 0);
    single("R10 R6 lookup after pair", 2'b11, 'h81, 0, 1, 4, 'hF006);
    pair("R10 delete then lookup", 2'b10, 'h81, 0, 2'b11, 'h81, 0,
         1, 4, 0, 1, 5, 'hF007);
  endtask

  task automatic t_idle();
    @(negedge clk); issue(2'b00, 'h34, 0);
    @(negedge clk);
    @(negedge clk); chk("R2 idle no pulse", int'(rsp_valid), 0);
    @(negedge clk); chk("R2 pulse single", int'(rsp_valid), 0);
  endtask

  task automatic t_full();
    int exp_idx = 4;
    for (int i = 0; i < 11; i++) begin
      single("R3 fill", 2'b01, 'h90 + i, 'h100 + i, 1, exp_idx, 0);
      exp_idx = (exp_idx == 4) ? 6 : exp_idx + 1;
    end
    chk("R9 full set", int'(tbl_full), 1);
    single("R9 insert rejected", 2'b01, 'hAA, 'h1234, 0, 0, 0);
    single("R9 rejected key absent", 2'b11, 'hAA, 0, 0, 0, 0);
    single("R9 contents kept", 2'b11, 'h34, 0, 1, 1, 'hB002);
    single("R7 delete in full", 2'b10, 'h90, 0, 1, 4, 0);
    chk("R9 full cleared", int'(tbl_full), 0);
    single("R7 R3 refill slot", 2'b01, 'hAA, 'h1234, 1, 4, 0);
    single("R4 lookup refill", 2'b11, 'hAA, 0, 1, 4, 'h1234);
    chk("R9 full again", int'(tbl_full), 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_dup();
    t_del_miss();
    t_b2b();
    t_idle();
    t_full();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule